// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block turns single host requests into bus cycles on a NAND flash device. Each request has an access class, which is command, address or data, and a direction. The block drives the command latch, the address latch, four active-low chip enables, the active-low read and write strobes, the data bus and its output enable. It also watches an active-low wait input from the flash. Every phase of an access is sized in system clock cycles by timing fields that software loads through a small configuration port.

An access runs through the same phases in order. First a setup phase holds the latch and chip-enable lines steady. A read then waits through a latch-to-read delay, chosen by whether the latest latch cycle was a command or an address. Next comes the strobe phase, which the wait input can stretch. A hold phase ends the access. On writes the data bus first stays tristated for a programmable count. The host sees `busy` while an access runs and a one-cycle `ack` when it ends. Requests are taken only while the block is idle.

Top module: `nand_seq`

## Requirements
- R1: After reset all chip enables, both strobes and both latches are inactive, `busy` and `dq_oe` are low, the bank is 0, the bus is 8 bits wide, and the timing fields hold setup=0, strobe=3, hold=2, tristate=0, command-to-read=0, address-to-read=0.
- R2: In every access, chip enable is active for exactly setup+1 cycles before the strobe falls. Reads also add the R6 delay.
- R3: The strobe (`we_n` on writes, `re_n` on reads) stays low for strobe+1 cycles, plus one cycle for each clock edge during the strobe at which `wait_n` is low. The two strobes are never low together.
- R4: After the strobe rises, chip enable, the active latch and the write data stay driven for hold+1 cycles. Chip enable is then released.
- R5: On a write, `dq_oe` is low for exactly tristate cycles, counted from the first chip-enable cycle. It then stays high until chip enable is released. It is never high during a read.
- R6: On a read, an extra delay of field+1 cycles comes between setup and the strobe. The field is the command-to-read field if the most recent command/address access was a command, and the address-to-read field otherwise. Only bits 3:0 of these fields are kept. The choice is command-to-read until the first latch access.
- R7: The bank field selects which bit of `ce_n` goes low during an access. At most one chip enable is ever active.
- R8: `req_kind` 0 is a command and raises `cle`. Value 1 is an address and raises `ale`. Values 2 and 3 are data and raise neither. Command and address accesses are always writes.
- R9: Width field bit 0 = 0 selects 8 bits: `dq_o` bits 15:8 are driven 0 and `rdata` bits 15:8 read 0. Bit 0 = 1 selects 16 bits. `rdata` is `dq_i` as sampled at the clock edge that ends the read strobe.
- R10: A request is accepted only when `req_valid` is high and `busy` is low. `busy` rises the cycle after acceptance and falls in the same cycle that `ack` pulses for exactly one cycle. A request raised while busy is ignored.
- R11: A config write with `cfg_we` high loads `cfg_data` into the field picked by `cfg_sel`: 0 setup, 1 strobe, 2 hold, 3 tristate, 4 command-to-read, 5 address-to-read, 6 bank (bits 1:0), 7 width (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_data | input | 8 | Configuration write value |
| req_valid | input | 1 | Host request |
| req_kind | input | 2 | Access class: 0 command, 1 address, 2/3 data |
| req_write | input | 1 | Direction of a data access (1 = write) |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read value |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 4 | Chip enables, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| dq_o | output | 16 | Data bus out |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | 16 | Data bus in |
| wait_n | input | 1 | Flash wait, active low |

## Verification
The bench drives `wait_n` low at random points, including the last strobe cycle. A design that counts the strobe even while wait is asserted, or that leaves the strobe phase while wait is low, gives a strobe width that does not match. Reads follow command and address accesses in mixed order, and the latch-delay fields are loaded with values that have upper bits set. This exposes the wrong delay being chosen and delay fields that keep more than four bits. The tristate count is swept from zero up past the whole access length, which catches the off-by-one mistake of treating this field as N+1 like the others. A request raised while busy checks that no second access starts.

// File: rtl/nand_seq.sv
module nand_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_data,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic        req_write,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        cle,
  output logic        ale,
  output logic [3:0]  ce_n,
  output logic        re_n,
  output logic        we_n,
  output logic [15:0] dq_o,
  output logic        dq_oe,
  input  logic [15:0] dq_i,
  input  logic        wait_n
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RDLY, S_STRB, S_HOLD} st_t;

  st_t         st;
  logic [7:0]  t_setup, t_strb, t_hold, t_hiz, cnt;
  logic [3:0]  t_c2r, t_a2r, dly_q;
  logic [1:0]  bank, bank_q, kind_q;
  logic        wide, wide_q, wr_q, last_cle;
  logic [15:0] wdata_q;
  logic [8:0]  elap;

  wire go       = req_valid && (st == S_IDLE);
  wire strb_end = (st == S_STRB) && wait_n && (cnt == t_strb);
  wire hold_end = (st == S_HOLD) && (cnt == t_hold);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t_setup <= 8'd0; t_strb <= 8'd3; t_hold <= 8'd2; t_hiz <= 8'd0;
      t_c2r <= 4'd0; t_a2r <= 4'd0; bank <= 2'd0; wide <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: t_setup <= cfg_data;
        3'd1: t_strb  <= cfg_data;
        3'd2: t_hold  <= cfg_data;
        3'd3: t_hiz   <= cfg_data;
        3'd4: t_c2r   <= cfg_data[3:0];
        3'd5: t_a2r   <= cfg_data[3:0];
        3'd6: bank    <= cfg_data[1:0];
        default: wide <= cfg_data[0];
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; elap <= '0; ack <= 1'b0; rdata <= '0;
      kind_q <= '0; wr_q <= 1'b0; wdata_q <= '0; bank_q <= '0; wide_q <= 1'b0;
      last_cle <= 1'b1; dly_q <= '0;
    end else begin
      ack <= hold_end;
      if (st != S_IDLE && elap != 9'h1FF) elap <= elap + 9'd1;
      case (st)
        S_IDLE: if (go) begin
          st      <= S_SETUP;
          cnt     <= '0;
          elap    <= '0;
          kind_q  <= req_kind;
          wr_q    <= !req_kind[1] || req_write;
          wdata_q <= wide ? req_wdata : {8'h00, req_wdata[7:0]};
          bank_q  <= bank;
          wide_q  <= wide;
          dly_q   <= last_cle ? t_c2r : t_a2r;
          if (!req_kind[1]) last_cle <= (req_kind == 2'd0);
        end
        S_SETUP: if (cnt == t_setup) begin
          cnt <= '0;
          st  <= wr_q ? S_STRB : S_RDLY;
        end else cnt <= cnt + 8'd1;
        S_RDLY: if (cnt == {4'h0, dly_q}) begin
          cnt <= '0; st <= S_STRB;
        end else cnt <= cnt + 8'd1;
        S_STRB: if (strb_end) begin
          cnt <= '0; st <= S_HOLD;
          if (!wr_q) rdata <= wide_q ? dq_i : {8'h00, dq_i[7:0]};
        end else if (wait_n) cnt <= cnt + 8'd1;
        S_HOLD: if (hold_end) st <= S_IDLE;
                else cnt <= cnt + 8'd1;
        default: st <= S_IDLE;
      endcase
    end

  assign busy  = (st != S_IDLE);
  assign cle   = busy && (kind_q == 2'd0);
  assign ale   = busy && (kind_q == 2'd1);
  assign ce_n  = busy ? ~(4'b0001 << bank_q) : 4'hF;
  assign we_n  = !((st == S_STRB) && wr_q);
  assign re_n  = !((st == S_STRB) && !wr_q);
  assign dq_oe = busy && wr_q && (elap >= {1'b0, t_hiz});
  assign dq_o  = wdata_q;

  p_strobes_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n) !(!re_n && !we_n));
  p_one_ce_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ce_n));
  p_latch_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  p_oe_not_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  p_busy_ends_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ack);
  p_strobe_holds_on_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !wait_n) |=> !we_n);
  p_ce_covers_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!re_n || !we_n) |-> (ce_n != 4'hF));
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [7:0] cfg_data = 0;
  logic req_valid = 0; logic [1:0] req_kind = 0; logic req_write = 0;
  logic [15:0] req_wdata = 0, dq_i = 0;
  logic wait_n = 1;
  logic busy, ack, cle, ale, re_n, we_n, dq_oe;
  logic [15:0] rdata, dq_o;
  logic [3:0] ce_n;

  int n_chk = 0, n_fail = 0;
  int m_setup = 0, m_strb = 3, m_hold = 2, m_hiz = 0, m_c2r = 0, m_a2r = 0, m_bank = 0, m_wide = 0;
  bit m_last_cle = 1;
  bit stall_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_seq uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pre(input bit wr);
    if (wr) return m_setup + 1;
    return m_setup + 1 + (m_last_cle ? m_c2r : m_a2r) + 1;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[2:0]; cfg_data = val[7:0];
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: m_setup = val & 255; 1: m_strb = val & 255; 2: m_hold = val & 255;
      3: m_hiz = val & 255; 4: m_c2r = val & 15; 5: m_a2r = val & 15;
      6: m_bank = val & 3; default: m_wide = val & 1;
    endcase
  endtask

  task automatic access(input int kind, input bit wr_in, input logic [15:0] wd,
                        input logic [15:0] rd, input bit poke_busy);
    int pre = 0, strb = 0, post = 0, stalls = 0, hz = 0, oe_hi = 0, acks = 0;
    int bad_latch = 0, bad_ce = 0, bad_dq = 0, busy_lo = 0;
    bit seen_oe = 0;
    bit wr = (kind < 2) ? 1'b1 : wr_in;
    int e_pre = exp_pre(wr);
    logic [15:0] e_wd = m_wide ? wd : {8'h00, wd[7:0]};
    logic [15:0] e_rd = m_wide ? rd : {8'h00, rd[7:0]};
    logic [3:0] e_ce = ~(4'b0001 << m_bank);
    int total;
    @(negedge clk);
    dq_i = rd; req_kind = kind[1:0]; req_write = wr_in; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R10 busy after accept", busy, 1);
    for (int i = 0; i < 5000 && acks == 0; i++) begin
      if (i > 0) @(negedge clk);
      if (poke_busy && i == 2) begin req_valid = 1; req_kind = 2'd0; end
      if (poke_busy && i == 3) req_valid = 0;
      if (ack) begin acks++; if (busy) busy_lo++; end
      else if (ce_n != 4'hF) begin
        if (ce_n != e_ce) bad_ce++;
        if (cle != (kind == 0) || ale != (kind == 1)) bad_latch++;
        if (!dq_oe && !seen_oe) hz++;
        if (dq_oe) begin seen_oe = 1; oe_hi++; if (dq_o != e_wd) bad_dq++; end
        if (!re_n || !we_n) begin
          if ((wr && we_n) || (!wr && re_n)) bad_latch++;
          strb++;
          wait_n = stall_en ? ($urandom % 3 != 0) : 1'b1;
          if (!wait_n) stalls++;
        end else begin
          wait_n = 1;
          if (strb == 0) pre++; else post++;
        end
      end
    end
    wait_n = 1;
    total = pre + strb + post;
    chk(acks == 1, "R10 ack seen", acks, 1);
    chk(busy_lo == 0, "R10 busy low with ack", busy_lo, 0);
    chk(pre == e_pre, wr ? "R2 setup length" : "R6 read delay length", pre, e_pre);
    chk(strb == m_strb + 1 + stalls, "R3 strobe length", strb, m_strb + 1 + stalls);
    chk(post == m_hold + 1, "R4 hold length", post, m_hold + 1);
    chk(bad_ce == 0, "R7 chip enable select", bad_ce, 0);
    chk(bad_latch == 0, "R8 latch and strobe class", bad_latch, 0);
    if (wr) begin
      chk(hz == min2(m_hiz, total), "R5 tristate count", hz, min2(m_hiz, total));
      chk(oe_hi == total - min2(m_hiz, total), "R5 drive after tristate", oe_hi, total - min2(m_hiz, total));
      chk(bad_dq == 0, "R9 write data width", bad_dq, 0);
    end else begin
      chk(oe_hi == 0, "R5 no drive on read", oe_hi, 0);
      chk(rdata == e_rd, "R9 read data", rdata, e_rd);
    end
    if (kind < 2) m_last_cle = (kind == 0);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && ce_n == 4'hF, "R10 request while busy ignored", {busy, ce_n}, 5'h0F);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ce_n == 4'hF && re_n && we_n && !cle && !ale, "R1 idle pins", {ce_n, re_n, we_n}, 6'h3F);
    chk(!busy && !dq_oe && !ack, "R1 idle handshake", {busy, dq_oe, ack}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    access(0, 1, 16'hA5C3, 16'h0, 0);        // R1 default timings, bank 0, narrow
    access(2, 0, 16'h0, 16'hBEEF, 0);        // R1 default read, 8-bit
    cfg(4, 8'hF3); cfg(5, 8'hA6);            // R6 upper bits dropped
    access(1, 1, 16'h0011, 16'h0, 0);
    access(2, 0, 16'h0, 16'h1234, 0);        // R6 address-to-read
    access(0, 1, 16'h0090, 16'h0, 0);
    access(2, 0, 16'h0, 16'h5678, 0);        // R6 command-to-read
    cfg(7, 1); cfg(6, 3); cfg(3, 2);         // R11 width, bank, tristate
    access(2, 1, 16'hCAFE, 16'h0, 0);        // R9 wide write
    access(3, 0, 16'h0, 16'h9ABC, 0);        // R9 wide read, kind 3
    cfg(3, 40);
    access(0, 1, 16'h0055, 16'h0, 0);        // R5 tristate past end
    cfg(3, 0); cfg(0, 2);
    access(2, 1, 16'h7777, 16'h0, 1);        // R10 request while busy
    stall_en = 1;
    for (int n = 0; n < 60; n++) begin
      cfg(0, $urandom % 4); cfg(1, $urandom % 5); cfg(2, $urandom % 4);
      cfg(3, $urandom % 9); cfg(4, $urandom); cfg(5, $urandom);
      cfg(6, $urandom % 4); cfg(7, $urandom % 2);
      access($urandom % 4, $urandom % 2, 16'($urandom), 16'($urandom), 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule